// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This block is the sequential multiply and divide engine of a 32-bit integer core. A caller sends a 6-bit function code and two 32-bit operands with a one-cycle start strobe. The unit then runs a shift-add multiply or a restoring divide, one bit per cycle. It writes the result into a pair of architectural result registers, HI and LO. Both registers drive their own output pins at all times, so move-from-HI and move-from-LO reads need no handshake.

The start pin is the request, and the inverse of the busy flag is the readiness to take one. A request is accepted only on a clock edge where start is high, busy is low and the function code names one of the four arithmetic operations. There is no queue. A request made while busy is dropped and not held, so the core must stall on busy itself. HI and LO change only in the cycle that finishes an operation, and both change together in that cycle.

Signed operations work on operand magnitudes and fix the signs in the last step. Division by zero is not trapped. It finishes in the normal time, and the HI and LO it leaves are not specified.

Top module: `muldiv_unit`

## Requirements
- R1: Function code 0x19 multiplies the operands as unsigned values. HI receives bits 63..32 of the 64-bit product and LO receives bits 31..0.
- R2: Function code 0x18 multiplies the operands as two's-complement values. The 64-bit signed product is split between HI (upper half) and LO (lower half).
- R3: Function code 0x1b divides opa_i by opb_i as unsigned values. LO receives the quotient and HI the remainder.
- R4: Function code 0x1a divides as two's-complement values. The quotient is truncated toward zero and the remainder has the sign of the dividend. 0x80000000 divided by -1 gives quotient 0x80000000 and remainder 0.
- R5: After an accepted start, busy_o is high for exactly 32 cycles, starting with the cycle after the accepting edge. The new HI and LO appear in the first cycle where busy_o is low again.
- R6: A start that arrives while busy_o is high is ignored. The running operation keeps its operands and its 32-cycle timing, and no second operation follows it.
- R7: A start carrying any function code other than 0x18, 0x19, 0x1a or 0x1b starts nothing. This includes the move codes 0x10 and 0x12. busy_o stays low and HI and LO keep their values.
- R8: HI and LO keep their previous values for the whole time busy_o is high. Both take their new values on the same clock edge.
- R9: A divide with a zero divisor raises no trap and completes with the normal 32-cycle busy period. The resulting HI and LO are unspecified.
- R10: While reset is held and after it is released, busy_o is low and HI and LO read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request strobe for one operation |
| func_i | input | 6 | Function code, low 6 bits of the R-type instruction |
| opa_i | input | 32 | First operand (multiplicand / dividend) |
| opb_i | input | 32 | Second operand (multiplier / divisor) |
| busy_o | output | 1 | Operation in progress; new requests are dropped |
| hi_o | output | 32 | Current HI register |
| lo_o | output | 32 | Current LO register |

## Verification
The bench uses operands at the edges of the signed range: 0x80000000 squared, all-ones squared, and the overflowing 0x80000000 / -1 divide. Every mix of operand signs is used for signed division. A unit that fixes signs wrongly would give a negated quotient or a remainder with the divisor's sign. Each operation's busy period is counted cycle by cycle, and HI/LO are sampled halfway through it. This exposes an off-by-one sequencer, or a unit that writes partial results before it finishes. A second request is injected in the middle of a multiply, and the move codes and an unused code are sent while idle. A unit that restarted, extended its busy period, or overwrote HI/LO from a non-arithmetic code would fail these checks.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

  localparam logic [5:0] FN_MFHI  = 6'h10;
  localparam logic [5:0] FN_MFLO  = 6'h12;
  localparam logic [5:0] FN_MULT  = 6'h18;
  localparam logic [5:0] FN_MULTU = 6'h19;
  localparam logic [5:0] FN_DIV   = 6'h1a;
  localparam logic [5:0] FN_DIVU  = 6'h1b;

  typedef enum logic [1:0] {
    K_NONE = 2'd0,
    K_MUL  = 2'd1,
    K_DIV  = 2'd2
  } kind_e;

  typedef struct packed {
    kind_e kind;
    logic  sgn;
  } opdec_t;

  function automatic opdec_t decode_fn(input logic [5:0] fn);
    opdec_t d;
    d.kind = K_NONE;
    d.sgn  = 1'b0;
    case (fn)
      FN_MULT:  begin d.kind = K_MUL; d.sgn = 1'b1; end
      FN_MULTU: begin d.kind = K_MUL; d.sgn = 1'b0; end
      FN_DIV:   begin d.kind = K_DIV; d.sgn = 1'b1; end
      FN_DIVU:  begin d.kind = K_DIV; d.sgn = 1'b0; end
      FN_MFHI, FN_MFLO: d.kind = K_NONE;
      default:  d.kind = K_NONE;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/muldiv_seq.sv
module muldiv_seq #(
  parameter int W = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic launch_i,
  output logic busy_o,
  output logic last_o
);
  localparam int CW = $clog2(W + 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  assign busy_o = busy_q;
  assign last_o = busy_q && (cnt_q == CW'(W - 1));

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (launch_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (last_o) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q < CW'(W))); // R5

  AST_CNT_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !last_o) |=> (busy_q && cnt_q == $past(cnt_q) + 1'b1)); // R6

  AST_IDLE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> !busy_q); // R6

endmodule

// File: rtl/mul_shift_add.sv
module mul_shift_add #(
  parameter int W = 32
) (
  input  logic           clk_i,
  input  logic           load_i,
  input  logic           step_i,
  input  logic [W-1:0]   mcand_i,
  input  logic [W-1:0]   mplier_i,
  output logic [2*W-1:0] prod_nxt_o
);
  logic [W-1:0]   mcand_q;
  logic [2*W-1:0] acc_q;
  logic [W:0]     sum;

  always_comb begin
    sum        = {1'b0, acc_q[2*W-1:W]} + (acc_q[0] ? {1'b0, mcand_q} : '0);
    prod_nxt_o = {sum, acc_q[W-1:1]};
  end

  always_ff @(posedge clk_i) begin
    if (load_i) begin
      mcand_q <= mcand_i;
      acc_q   <= {{W{1'b0}}, mplier_i};
    end else if (step_i) begin
      acc_q <= prod_nxt_o;
    end
  end

endmodule

// File: rtl/div_restoring.sv
module div_restoring #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] dvnd_i,
  input  logic [W-1:0] dvsr_i,
  output logic [W-1:0] quo_nxt_o,
  output logic [W-1:0] rem_nxt_o
);
  logic [W-1:0] dvsr_q;
  logic [W-1:0] rem_q;
  logic [W-1:0] quo_q;
  logic [W:0]   shifted;
  logic [W:0]   trial;
  logic         take;

  always_comb begin
    shifted   = {rem_q, quo_q[W-1]};
    trial     = shifted - {1'b0, dvsr_q};
    take      = !trial[W];
    rem_nxt_o = take ? trial[W-1:0] : shifted[W-1:0];
    quo_nxt_o = {quo_q[W-2:0], take};
  end

  always_ff @(posedge clk_i) begin
    if (load_i) begin
      dvsr_q <= dvsr_i;
      rem_q  <= '0;
      quo_q  <= dvnd_i;
    end else if (step_i) begin
      rem_q <= rem_nxt_o;
      quo_q <= quo_nxt_o;
    end
  end

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [5:0]   func_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  output logic         busy_o,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o
);
  opdec_t         dec;
  logic           accept;
  logic           busy_w;
  logic           last_w;
  logic           a_neg, b_neg;
  logic [W-1:0]   a_mag, b_mag;

  kind_e          kind_q;
  logic           neg_main_q;
  logic           neg_rem_q;
  logic [W-1:0]   mag_a_q, mag_b_q;
  logic [W-1:0]   hi_q, lo_q;

  logic [2*W-1:0] prod_mag, prod_fin;
  logic [W-1:0]   quo_mag, rem_mag, quo_fin, rem_fin;

  assign dec    = decode_fn(func_i);
  assign accept = start_i && (dec.kind != K_NONE) && !busy_w;

  always_comb begin
    a_neg = dec.sgn & opa_i[W-1];
    b_neg = dec.sgn & opb_i[W-1];
    a_mag = a_neg ? (~opa_i + 1'b1) : opa_i;
    b_mag = b_neg ? (~opb_i + 1'b1) : opb_i;
  end

  muldiv_seq #(.W(W)) seq_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .launch_i (accept),
    .busy_o   (busy_w),
    .last_o   (last_w)
  );

  mul_shift_add #(.W(W)) mul_i (
    .clk_i      (clk_i),
    .load_i     (accept),
    .step_i     (busy_w),
    .mcand_i    (a_mag),
    .mplier_i   (b_mag),
    .prod_nxt_o (prod_mag)
  );

  div_restoring #(.W(W)) div_i (
    .clk_i     (clk_i),
    .load_i    (accept),
    .step_i    (busy_w),
    .dvnd_i    (a_mag),
    .dvsr_i    (b_mag),
    .quo_nxt_o (quo_mag),
    .rem_nxt_o (rem_mag)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      kind_q     <= K_NONE;
      neg_main_q <= 1'b0;
      neg_rem_q  <= 1'b0;
      mag_a_q    <= '0;
      mag_b_q    <= '0;
    end else if (accept) begin
      kind_q     <= dec.kind;
      neg_main_q <= a_neg ^ b_neg;
      neg_rem_q  <= a_neg;
      mag_a_q    <= a_mag;
      mag_b_q    <= b_mag;
    end
  end

  always_comb begin
    prod_fin = neg_main_q ? (~prod_mag + 1'b1) : prod_mag;
    quo_fin  = neg_main_q ? (~quo_mag + 1'b1) : quo_mag;
    rem_fin  = neg_rem_q  ? (~rem_mag + 1'b1) : rem_mag;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (last_w) begin
      if (kind_q == K_MUL) begin
        hi_q <= prod_fin[2*W-1:W];
        lo_q <= prod_fin[W-1:0];
      end else begin
        hi_q <= rem_fin;
        lo_q <= quo_fin;
      end
    end
  end

  assign busy_o = busy_w;
  assign hi_o   = hi_q;
  assign lo_o   = lo_q;

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_w |=> ($stable(hi_q) && $stable(lo_q))); // R8

  AST_LAUNCH_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && dec.kind != K_NONE && !busy_w) |=> busy_w); // R5

  AST_NOP_FUNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && dec.kind == K_NONE && !busy_w) |=> !busy_w); // R7

  AST_MUL_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_w && kind_q == K_MUL) |->
      (prod_mag == ({{W{1'b0}}, mag_a_q} * {{W{1'b0}}, mag_b_q}))); // R1

  AST_DIV_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_w && kind_q == K_DIV && mag_b_q != '0) |->
      ((({{W{1'b0}}, quo_mag} * {{W{1'b0}}, mag_b_q}) + {{W{1'b0}}, rem_mag})
         == {{W{1'b0}}, mag_a_q} && rem_mag < mag_b_q)); // R3

endmodule

// File: tb/muldiv_unit_tb.sv
module muldiv_unit_tb_top;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [5:0]  func_i = 6'h0;
  logic [31:0] opa_i = '0;
  logic [31:0] opb_i = '0;
  logic        busy_o;
  logic [31:0] hi_o, lo_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk_i = ~clk_i;

  muldiv_unit #(.W(32)) dut_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .func_i (func_i),
    .opa_i  (opa_i),
    .opb_i  (opb_i),
    .busy_o (busy_o),
    .hi_o   (hi_o),
    .lo_o   (lo_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_model(input logic [5:0] fn,
                                            input logic [31:0] a, input logic [31:0] b);
    logic signed [63:0] sa, sb, q, r;
    logic [63:0] p;
    sa = $signed({{32{a[31]}}, a});
    sb = $signed({{32{b[31]}}, b});
    case (fn)
      6'h18: begin p = sa * sb; return p; end
      6'h19: begin p = {32'b0, a} * {32'b0, b}; return p; end
      6'h1a: begin q = sa / sb; r = sa % sb; return {r[31:0], q[31:0]}; end
      default: return {a % b, a / b};
    endcase
  endfunction

  // One arithmetic operation; optional injection of a second start while busy
  task automatic run_op(input logic [5:0] fn, input logic [31:0] a, input logic [31:0] b,
                        input bit chk, input string req, input int inj_at,
                        input logic [5:0] inj_fn);
    logic [31:0] hi0, lo0;
    logic [63:0] exp;
    int cnt;
    hi0 = hi_o;
    lo0 = lo_o;
    exp = ref_model(fn, a, b);
    cnt = 0;
    @(negedge clk_i);
    start_i = 1'b1; func_i = fn; opa_i = a; opb_i = b;
    @(negedge clk_i);
    start_i = 1'b0;
    while (busy_o && cnt < 100) begin
      cnt++;
      if (cnt == 16)
        check(hi_o == hi0 && lo_o == lo0, "R8", "HI/LO held mid-operation",
              {hi_o, lo_o}, {hi0, lo0});
      if (cnt == inj_at) begin
        start_i = 1'b1; func_i = inj_fn; opa_i = ~a; opb_i = b + 1;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk_i);
    end
    start_i = 1'b0;
    check(cnt == 32, "R5", "busy cycle count", 64'(cnt), 64'd32);
    if (chk)
      check({hi_o, lo_o} == exp, req, "HI:LO result", {hi_o, lo_o}, exp);
    @(negedge clk_i);
    if (inj_at > 0)
      check(!busy_o, "R6", "no follow-on operation", 64'(busy_o), 64'd0);
  endtask

  task automatic t_reset;
    check(!busy_o, "R10", "busy after reset", 64'(busy_o), 64'd0);
    check(hi_o == 0 && lo_o == 0, "R10", "HI/LO after reset", {hi_o, lo_o}, 64'd0);
  endtask

  task automatic t_mul_unsigned;
    run_op(6'h19, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R1", -1, 6'h0);
    run_op(6'h19, 32'h1234_5678, 32'h9ABC_DEF0, 1'b1, "R1", -1, 6'h0);
  endtask

  task automatic t_mul_signed;
    run_op(6'h18, -32'sd3, 32'd7, 1'b1, "R2", -1, 6'h0);
    run_op(6'h18, 32'h8000_0000, 32'h8000_0000, 1'b1, "R2", -1, 6'h0);
    run_op(6'h18, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R2", -1, 6'h0);
    run_op(6'h18, 32'h7FFF_FFFF, 32'h8000_0000, 1'b1, "R2", -1, 6'h0);
  endtask

  task automatic t_div_unsigned;
    run_op(6'h1b, 32'd100, 32'd7, 1'b1, "R3", -1, 6'h0);
    run_op(6'h1b, 32'hFFFF_FFFF, 32'h10, 1'b1, "R3", -1, 6'h0);
    run_op(6'h1b, 32'd5, 32'd9, 1'b1, "R3", -1, 6'h0);
  endtask

  task automatic t_div_signed;
    run_op(6'h1a, -32'sd7, 32'd2, 1'b1, "R4", -1, 6'h0);
    run_op(6'h1a, 32'd7, -32'sd2, 1'b1, "R4", -1, 6'h0);
    run_op(6'h1a, -32'sd7, -32'sd2, 1'b1, "R4", -1, 6'h0);
    run_op(6'h1a, 32'h8000_0000, 32'hFFFF_FFFF, 1'b1, "R4", -1, 6'h0);
    check(lo_o == 32'h8000_0000 && hi_o == 0, "R4", "overflow divide",
          {hi_o, lo_o}, {32'h0, 32'h8000_0000});
  endtask

  task automatic t_ignore_busy;
    run_op(6'h19, 32'd3, 32'd5, 1'b1, "R6", 5, 6'h1b);
    run_op(6'h1a, 32'd1000, 32'd3, 1'b1, "R6", 20, 6'h18);
  endtask

  task automatic t_nop_codes;
    logic [5:0] codes [3];
    logic [31:0] hi0, lo0;
    codes[0] = 6'h10; codes[1] = 6'h12; codes[2] = 6'h20;
    for (int i = 0; i < 3; i++) begin
      hi0 = hi_o; lo0 = lo_o;
      @(negedge clk_i);
      start_i = 1'b1; func_i = codes[i]; opa_i = 32'hDEAD_BEEF; opb_i = 32'h1;
      @(negedge clk_i);
      start_i = 1'b0;
      check(!busy_o, "R7", "busy after non-arith code", 64'(busy_o), 64'd0);
      @(negedge clk_i);
      check(hi_o == hi0 && lo_o == lo0, "R7", "HI/LO after non-arith code",
            {hi_o, lo_o}, {hi0, lo0});
    end
  endtask

  task automatic t_div_zero;
    run_op(6'h1b, 32'd5, 32'd0, 1'b0, "R9", -1, 6'h0);
    check(!busy_o, "R9", "idle after divide by zero", 64'(busy_o), 64'd0);
    run_op(6'h1a, -32'sd9, 32'd0, 1'b0, "R9", -1, 6'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_mul_unsigned();
    t_mul_signed();
    t_div_unsigned();
    t_div_signed();
    t_ignore_busy();
    t_nop_codes();
    t_div_zero();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    end
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    end
    $finish;
  end

endmodule